// File: doc/BRIEF.md
# CPU Wait-State Generator with Selectable Timing

This block produces the active-low WAIT input of an 8-bit CPU on a plug-in processor card. It watches the CPU's bus strobes: opcode-fetch, memory request, read and write. When a memory bus cycle begins that qualifies under the selected timing mode, it stretches that cycle by a fixed number of CPU clock periods. A two-bit code from a three-position switch picks the mode. A wait request from the backplane, also active-low, is merged into the output. Devices on the bus can therefore always stretch a cycle further than the generated waits.

The internal wait is changed only on the rising clock edge. The CPU samples WAIT on the falling edge, so the signal has half a clock period to settle and never moves near the sampling point. A build parameter selects an alternate mode mapping, meant for running the card nearer its speed limit.

Top module: `cpu_wait_gen`

## Requirements
- R1: A synchronous reset (`rst` high) clears the generated wait. During reset and on the first cycle after it, `cpu_wait_n` equals `ext_wait_n`, even if a bus cycle is in progress.
- R2: In the standard mapping, mode code 2'b00 (NORMAL) inserts exactly one wait clock. It does so only on opcode-fetch cycles, which have `m1_n` and `mreq_n` both low. A plain memory read or write gets no wait.
- R3: In the standard mapping, mode code 2'b01 (MIDDLE) inserts `MID_WAITS` wait clocks (default 3) on every memory cycle where `rd_n` or `wr_n` is low. Opcode fetches count as memory reads.
- R4: In the standard mapping, mode code 2'b10 (FAST) inserts exactly one wait clock on every memory cycle where `rd_n` or `wr_n` is low.
- R5: Some cycles get no generated wait: a cycle with `mreq_n` low but neither qualifying strobe low (a refresh cycle), and any strobe activity while `mreq_n` is high. Code 2'b11 behaves as NORMAL.
- R6: The trigger is the first rising clock edge at which `mreq_n` is low and the mode's qualifier holds. `cpu_wait_n` goes low right after that edge, stays low for exactly the wait count in clock periods, and changes only after rising edges.
- R7: A memory cycle triggers at most once. No new trigger occurs until `mreq_n` has been sampled high.
- R8: `cpu_wait_n` is low whenever `ext_wait_n` is low, regardless of mode or internal state.
- R9: The wait count is fixed when the cycle triggers. A change of `mode_sel` after that point does not alter the count in progress.
- R10: With `ALT_MAP=1`, MIDDLE inserts one wait on every memory read or write. NORMAL, FAST and code 2'b11 insert one wait on opcode fetches only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mode_sel | input | 2 | Timing mode: 00 NORMAL, 01 MIDDLE, 10 FAST, 11 as NORMAL |
| ext_wait_n | input | 1 | Backplane wait request, active low |
| cpu_wait_n | output | 1 | Combined wait to the CPU, active low |

## Verification
The hardest case to reach is a write cycle. Its write strobe arrives one clock after the memory request, so the trigger must come on a later edge than the start of the request. The bench therefore lowers `wr_n` one clock into each write cycle and checks that the first wait sample moves by one period. Exhaustive sweeps over every mode code and every cycle kind run on a standard instance and an alternate-map instance driven side by side. Each cycle holds the memory request longer than the longest wait, so a retrigger would show as extra wait clocks. Separate sequences switch the mode mid-wait, assert reset mid-wait and hold the backplane wait low.

// File: rtl/cpu_wait_pkg.sv
package cpu_wait_pkg;

    localparam int unsigned WCNT_W = 4;

    typedef enum logic [1:0] {
        SEL_NORMAL = 2'b00,
        SEL_MIDDLE = 2'b01,
        SEL_FAST   = 2'b10,
        SEL_SPARE  = 2'b11
    } wait_sel_e;

    typedef enum logic [0:0] {
        TRIG_OPFETCH = 1'b0,
        TRIG_MEMACC  = 1'b1
    } trig_kind_e;

    typedef struct packed {
        trig_kind_e          kind;
        logic [WCNT_W-1:0]   count;
    } wait_plan_t;

endpackage

// File: rtl/wait_mode_map.sv
module wait_mode_map
    import cpu_wait_pkg::*;
#(
    parameter int unsigned ALT_MAP   = 0,
    parameter int unsigned MID_WAITS = 3
) (
    input  logic [1:0] mode_sel,
    output wait_plan_t plan
);

    localparam logic [WCNT_W-1:0] ONE_WAIT = WCNT_W'(1);
    localparam logic [WCNT_W-1:0] MID_CNT  = WCNT_W'(MID_WAITS);

    generate
        if (ALT_MAP == 0) begin : g_std_map
            always_comb begin
                case (wait_sel_e'(mode_sel))
                    SEL_MIDDLE: plan = '{kind: TRIG_MEMACC,  count: MID_CNT};
                    SEL_FAST:   plan = '{kind: TRIG_MEMACC,  count: ONE_WAIT};
                    default:    plan = '{kind: TRIG_OPFETCH, count: ONE_WAIT};
                endcase
            end
        end else begin : g_alt_map
            always_comb begin
                case (wait_sel_e'(mode_sel))
                    SEL_MIDDLE: plan = '{kind: TRIG_MEMACC,  count: ONE_WAIT};
                    default:    plan = '{kind: TRIG_OPFETCH, count: ONE_WAIT};
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/wait_trig_detect.sv
module wait_trig_detect
    import cpu_wait_pkg::*;
(
    input  trig_kind_e kind,
    input  logic       m1_n,
    input  logic       mreq_n,
    input  logic       rd_n,
    input  logic       wr_n,
    output logic       qual_hit
);

    logic fetch_seen;
    logic access_seen;

    always_comb begin
        fetch_seen  = !m1_n;
        access_seen = !rd_n || !wr_n;
        qual_hit    = !mreq_n &&
                      ((kind == TRIG_OPFETCH) ? fetch_seen : access_seen);
    end

endmodule

// File: rtl/wait_cycle_ctrl.sv
module wait_cycle_ctrl #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mreq_n,
    input  logic             qual_hit,
    input  logic [CNT_W-1:0] load_count,
    output logic             gen_wait
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t st_d;
    ctrl_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (mreq_n) begin
            st_d.armed = 1'b1;
        end else if (st_q.armed && qual_hit) begin
            st_d.armed = 1'b0;
            st_d.cnt   = load_count;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{armed: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gen_wait = (st_q.cnt != '0);

endmodule

// File: rtl/cpu_wait_gen.sv
module cpu_wait_gen
    import cpu_wait_pkg::*;
#(
    parameter int unsigned ALT_MAP   = 0,
    parameter int unsigned MID_WAITS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       m1_n,
    input  logic       mreq_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] mode_sel,
    input  logic       ext_wait_n,
    output logic       cpu_wait_n
);

    wait_plan_t plan;
    logic       qual_hit;
    logic       gen_wait;

    wait_mode_map #(
        .ALT_MAP   (ALT_MAP),
        .MID_WAITS (MID_WAITS)
    ) u_map (
        .mode_sel (mode_sel),
        .plan     (plan)
    );

    wait_trig_detect u_detect (
        .kind     (plan.kind),
        .m1_n     (m1_n),
        .mreq_n   (mreq_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .qual_hit (qual_hit)
    );

    wait_cycle_ctrl #(
        .CNT_W (WCNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mreq_n     (mreq_n),
        .qual_hit   (qual_hit),
        .load_count (plan.count),
        .gen_wait   (gen_wait)
    );

    assign cpu_wait_n = ext_wait_n && !gen_wait;

endmodule

// File: rtl/wait_gen_checker.sv
module wait_gen_checker #(
    parameter int unsigned ALT_MAP   = 0,
    parameter int unsigned MID_WAITS = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       m1_n,
    input logic       mreq_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] mode_sel,
    input logic       ext_wait_n,
    input logic       cpu_wait_n,
    input logic       gen_wait
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cpu_wait_n == ext_wait_n));

    assert_ext_pass_R8: assert property (@(posedge clk) disable iff (rst)
        !ext_wait_n |-> !cpu_wait_n);

    assert_start_in_mreq_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(gen_wait) |-> $past(!mreq_n));

    assert_qualified_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(gen_wait) |-> $past(!m1_n || !rd_n || !wr_n));

    assert_single_wait_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(gen_wait) && ($past(mode_sel) != 2'b01)) |=> !gen_wait);

    assert_middle_len_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(gen_wait) && ($past(mode_sel) == 2'b01) &&
         (ALT_MAP == 0) && (MID_WAITS >= 2)) |=> gen_wait);

    assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(gen_wait) && !mreq_n && $past(!mreq_n)) |=> !gen_wait);

endmodule

bind cpu_wait_gen wait_gen_checker #(
    .ALT_MAP   (ALT_MAP),
    .MID_WAITS (MID_WAITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .m1_n       (m1_n),
    .mreq_n     (mreq_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .mode_sel   (mode_sel),
    .ext_wait_n (ext_wait_n),
    .cpu_wait_n (cpu_wait_n),
    .gen_wait   (gen_wait)
);

// File: tb/cpu_wait_gen_bench.sv
`timescale 1ns/1ps
module cpu_wait_gen_bench;

    localparam int HOLD = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m1_n = 1'b1;
    logic       mreq_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       ext_wait_n = 1'b1;
    logic       wait_std_n;
    logic       wait_alt_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cpu_wait_gen #(.ALT_MAP(0), .MID_WAITS(3)) u_cpu_wait_gen (
        .clk(clk), .rst(rst), .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n),
        .wr_n(wr_n), .mode_sel(mode_sel), .ext_wait_n(ext_wait_n),
        .cpu_wait_n(wait_std_n)
    );

    cpu_wait_gen #(.ALT_MAP(1), .MID_WAITS(3)) u_cpu_wait_gen_alt (
        .clk(clk), .rst(rst), .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n),
        .wr_n(wr_n), .mode_sel(mode_sel), .ext_wait_n(ext_wait_n),
        .cpu_wait_n(wait_alt_n)
    );

    // kinds: 0 opcode fetch, 1 memory read, 2 memory write,
    //        3 refresh (mreq only), 4 read strobe without mreq
    function automatic int exp_waits(int alt, int mode, int kind);
        bit is_fetch = (kind == 0);
        bit is_mem   = (kind <= 2);
        if (alt == 0) begin
            if (mode == 1) return is_mem ? 3 : 0;
            if (mode == 2) return is_mem ? 1 : 0;
            return is_fetch ? 1 : 0;
        end
        if (mode == 1) return is_mem ? 1 : 0;
        return is_fetch ? 1 : 0;
    endfunction

    function automatic string req_tag(int alt, int mode, int kind);
        if (alt != 0) return "R10";
        if (kind >= 3) return "R5";
        if (mode == 1) return "R3";
        if (mode == 2) return "R4";
        return "R2";
    endfunction

    task automatic check_int(string req, string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drives one bus cycle; mode switches to mode_b after the first sample (R9).
    task automatic run_bus(int kind, int mode_a, int mode_b);
        int cnt_s = 0, cnt_a = 0, first_s = -1, first_a = -1;
        int exp_first_s, exp_first_a;
        @(negedge clk);
        mode_sel = 2'(mode_a);
        mreq_n = (kind == 4);
        m1_n   = !(kind == 0);
        rd_n   = !(kind == 0 || kind == 1 || kind == 4);
        wr_n   = 1'b1;
        for (int i = 0; i < HOLD + 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (!wait_std_n) begin cnt_s++; if (first_s < 0) first_s = i; end
            if (!wait_alt_n) begin cnt_a++; if (first_a < 0) first_a = i; end
            if (i == 0) begin
                mode_sel = 2'(mode_b);
                if (kind == 2) wr_n = 1'b0;
            end
            if (i == HOLD - 1) begin
                mreq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
            end
        end
        exp_first_s = (exp_waits(0, mode_a, kind) == 0) ? -1 : ((kind == 2) ? 1 : 0);
        exp_first_a = (exp_waits(1, mode_a, kind) == 0) ? -1 : ((kind == 2) ? 1 : 0);
        check_int(req_tag(0, mode_a, kind), $sformatf("std wait count m%0d k%0d", mode_a, kind),
                  cnt_s, exp_waits(0, mode_a, kind));
        check_int(req_tag(1, mode_a, kind), $sformatf("alt wait count m%0d k%0d", mode_a, kind),
                  cnt_a, exp_waits(1, mode_a, kind));
        check_int("R6", $sformatf("std first wait m%0d k%0d", mode_a, kind), first_s, exp_first_s);
        check_int("R6", $sformatf("alt first wait m%0d k%0d", mode_a, kind), first_a, exp_first_a);
    endtask

    initial begin
        // R1: reset with an opcode fetch on the bus
        mreq_n = 1'b0; m1_n = 1'b0; rd_n = 1'b0;
        idle(3);
        check_int("R1", "std during reset", int'(wait_std_n), 1);
        check_int("R1", "alt during reset", int'(wait_alt_n), 1);
        rst = 1'b0;
        @(negedge clk);
        check_int("R1", "std first cycle after reset", int'(wait_std_n), 1);
        mreq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1;
        idle(2);

        // Exhaustive sweep: all mode codes x all cycle kinds (R2-R7, R10)
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 5; k++) begin
                run_bus(k, m, m);
            end
        end

        // R9: mode change mid-wait does not alter the count
        run_bus(1, 1, 2);
        run_bus(0, 2, 1);

        // R8: backplane wait passes through while idle
        @(negedge clk);
        ext_wait_n = 1'b0;
        @(negedge clk);
        check_int("R8", "std ext passthrough", int'(wait_std_n), 0);
        check_int("R8", "alt ext passthrough", int'(wait_alt_n), 0);
        ext_wait_n = 1'b1;
        @(negedge clk);
        check_int("R8", "std ext release", int'(wait_std_n), 1);

        // R8: ext wait extends a MIDDLE read beyond the generated waits
        mode_sel = 2'b01; mreq_n = 1'b0; rd_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 0) ext_wait_n = 1'b0;
        end
        check_int("R8", "std ext after internal waits", int'(wait_std_n), 0);
        ext_wait_n = 1'b1;
        @(negedge clk);
        check_int("R7", "std no retrigger, ext released", int'(wait_std_n), 1);
        mreq_n = 1'b1; rd_n = 1'b1;
        idle(2);

        // R1: reset in the middle of a MIDDLE wait
        mode_sel = 2'b01; mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        check_int("R3", "std wait before reset", int'(wait_std_n), 0);
        rst = 1'b1;
        @(negedge clk);
        check_int("R1", "std reset clears wait", int'(wait_std_n), 1);
        rst = 1'b0;
        @(negedge clk);
        check_int("R7", "std no trigger inside open cycle after reset", int'(wait_std_n), 1);
        mreq_n = 1'b1; rd_n = 1'b1;
        idle(2);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule